// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block sits on the device side of a byte-wide parallel flash read port. While an internal program or erase operation runs, it drives a status byte on reads instead of array contents. Bit 7 is a polling bit that tells a host whether the operation has finished. Bit 6 is a toggle bit that inverts on every read access. Bit 5 is a sticky flag that marks an operation that ran past its internal limit. Once the operation ends, reads return array data again.

A timer-based operation model outside this block performs the actual program or erase. It reports back through done and fail inputs. This block decides whether an operation really runs or only pretends to be busy:

- A program aimed at a protected sector produces a short fake-busy window.
- An erase whose selected sectors are all protected produces a long fake-busy window.
- In any other erase, the mask of sectors to erase leaves out the protected ones.

An external level input keeps status reads active while an erase is suspended or sits in its sector-erase timeout window.

Top module: `flash_op_status`

## Requirements
- R1: After reset the block is idle. `dq_en_o` is high exactly when `ce_n`, `oe_n` are low and `we_n` is high. While idle with `erase_hold_i` low, an active read returns `arr_data_i`. With no active read, `dq_o` is 0.
- R2: While a program runs, bit 7 of a status read is the inverse of bit 7 of the byte latched at start. `run_o` is 1 while the real operation runs.
- R3: While an erase runs, bit 7 of a status read is 0.
- R4: While status is shown, bit 6 inverts once per read access. A read access is the start of a read, caused either by `oe_n` falling while `ce_n` is low or by `ce_n` falling while `oe_n` is low. The status byte is {poll, toggle, fail, 5'b00000}, with bits 4..0 always 0. The toggle bit is 0 after reset.
- R5: After `model_done_i` ends a running operation, reads return `arr_data_i` and bit 6 no longer changes.
- R6: A program start on a sector whose protect flag is 1 shows status for CLK_MHZ*PROG_GUARD_US cycles with `run_o` low, then returns to array reads.
- R7: An erase start whose selected sectors are all protected shows erase status for CLK_MHZ*ERASE_GUARD_US cycles, sets `erase_mask_o` to 0 and keeps `run_o` low, then returns to array reads.
- R8: `model_fail_i` during a running operation sets bit 5 of status reads. The flag stays set and `model_done_i` is ignored until `reset_cmd_i` returns the block to idle.
- R9: An accepted erase start sets `erase_mask_o` to `erase_sel_i & ~sect_prot_i`.
- R10: While `erase_hold_i` is 1 in idle, reads return status with bit 7 at 0 and a toggling bit 6.
- R11: `op_start_i` is ignored unless the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a read needs it high |
| op_start_i | input | 1 | One-cycle start of an operation |
| op_kind_i | input | 1 | 0 program, 1 erase |
| sect_i | input | SW | Target sector of a program |
| erase_sel_i | input | NSECT | Sectors selected for erase |
| sect_prot_i | input | NSECT | Per-sector protect flags |
| prog_byte_i | input | 8 | Byte being programmed |
| erase_hold_i | input | 1 | Erase suspended or in its timeout window |
| model_done_i | input | 1 | Operation model finished |
| model_fail_i | input | 1 | Operation model exceeded its limit |
| reset_cmd_i | input | 1 | Reset command, clears the failure |
| arr_data_i | input | 8 | Array data for normal reads |
| dq_o | output | 8 | Read data bus |
| dq_en_o | output | 1 | Read data bus drive enable |
| run_o | output | 1 | Real operation running |
| erase_mask_o | output | NSECT | Sectors the model is to erase |

## Verification
The status encoding is driven with three kinds of operation:

- A program of a byte with bit 7 clear and one with bit 7 set. Comparing the two shows the polling bit is the inverse of that bit and not a constant.
- A real erase, whose polling bit is 0.
- Two protected cases, one a program and one an erase, which tell a fake-busy window apart from a real run by `run_o`, the mask and the moment array data returns.

Reads are made both by pulsing the output enable and by pulsing the chip enable. A failure followed by a stray done, and a start issued while busy, show that the sticky flag and the idle-only start rule hold.

// File: rtl/fst_pkg.sv
package fst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FAKE = 2'd2,
        ST_FAIL = 2'd3
    } fst_state_e;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } fst_op_e;
endpackage

// File: rtl/fst_rd_access.sv
module fst_rd_access (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic rd_en_o,
    output logic access_o
);
    logic prev_d, prev_q;

    always_comb begin
        rd_en_o  = !ce_n && !oe_n && we_n;
        prev_d   = rd_en_o;
        access_o = rd_en_o && !prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // R4: an access is only the first cycle of a read
    a_r4_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        access_o |=> !access_o);
endmodule

// File: rtl/fst_guard_timer.sv
module fst_guard_timer #(
    parameter int SHORT_CYC = 20,
    parameter int LONG_CYC  = 1000,
    parameter int CW        = $clog2(LONG_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic long_i,
    output logic expire_o
);
    localparam logic [CW-1:0] SHORT_V = CW'(SHORT_CYC);
    localparam logic [CW-1:0] LONG_V  = CW'(LONG_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)              cnt_d = long_i ? LONG_V : SHORT_V;
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
        expire_o = (cnt_q == CW'(1)) && !load_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6 R7: window never exceeds the long limit
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LONG_V);
    a_r6_cnt_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fst_status_mux.sv
module fst_status_mux (
    input  logic       rd_en_i,
    input  logic       show_stat_i,
    input  logic       poll_i,
    input  logic       tog_i,
    input  logic       fail_i,
    input  logic [7:0] arr_i,
    output logic [7:0] dq_o
);
    always_comb begin
        if (!rd_en_i)         dq_o = 8'h00;
        else if (show_stat_i) dq_o = {poll_i, tog_i, fail_i, 5'b00000};
        else                  dq_o = arr_i;
    end
endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
    import fst_pkg::*;
#(
    parameter int NSECT          = 8,
    parameter int CLK_MHZ        = 10,
    parameter int PROG_GUARD_US  = 2,
    parameter int ERASE_GUARD_US = 100,
    parameter int SW             = (NSECT > 1) ? $clog2(NSECT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             oe_n,
    input  logic             we_n,
    input  logic             op_start_i,
    input  logic             op_kind_i,
    input  logic [SW-1:0]    sect_i,
    input  logic [NSECT-1:0] erase_sel_i,
    input  logic [NSECT-1:0] sect_prot_i,
    input  logic [7:0]       prog_byte_i,
    input  logic             erase_hold_i,
    input  logic             model_done_i,
    input  logic             model_fail_i,
    input  logic             reset_cmd_i,
    input  logic [7:0]       arr_data_i,
    output logic [7:0]       dq_o,
    output logic             dq_en_o,
    output logic             run_o,
    output logic [NSECT-1:0] erase_mask_o
);
    localparam int PROG_CYC  = CLK_MHZ * PROG_GUARD_US;
    localparam int ERASE_CYC = CLK_MHZ * ERASE_GUARD_US;
    localparam int CW        = $clog2(ERASE_CYC + 1);

    typedef struct packed {
        fst_state_e       st;
        fst_op_e          kind;
        logic             bit7;
        logic             tog;
        logic [NSECT-1:0] mask;
    } ctl_t;

    ctl_t r_d, r_q;

    logic             rd_en, access, expire, load, load_long;
    logic             active, poll;
    logic [NSECT-1:0] live_mask;

    fst_rd_access u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .rd_en_o  (rd_en),
        .access_o (access)
    );

    fst_guard_timer #(
        .SHORT_CYC (PROG_CYC),
        .LONG_CYC  (ERASE_CYC),
        .CW        (CW)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .long_i   (load_long),
        .expire_o (expire)
    );

    always_comb begin
        r_d       = r_q;
        load      = 1'b0;
        load_long = 1'b0;
        live_mask = erase_sel_i & ~sect_prot_i;
        active    = (r_q.st != ST_IDLE) || erase_hold_i;
        if (access && active) r_d.tog = ~r_q.tog;

        unique case (r_q.st)
            ST_IDLE: begin
                if (op_start_i) begin
                    if (op_kind_i == 1'b0) begin
                        r_d.kind = OP_PROG;
                        r_d.bit7 = prog_byte_i[7];
                        if (sect_prot_i[sect_i]) begin
                            r_d.st = ST_FAKE;
                            load   = 1'b1;
                        end else begin
                            r_d.st = ST_RUN;
                        end
                    end else begin
                        r_d.kind = OP_ERASE;
                        r_d.mask = live_mask;
                        if (live_mask == '0) begin
                            r_d.st    = ST_FAKE;
                            load      = 1'b1;
                            load_long = 1'b1;
                        end else begin
                            r_d.st = ST_RUN;
                        end
                    end
                end
            end
            ST_RUN: begin
                if (model_fail_i)      r_d.st = ST_FAIL;
                else if (model_done_i) r_d.st = ST_IDLE;
            end
            ST_FAKE: begin
                if (expire) r_d.st = ST_IDLE;
            end
            ST_FAIL: begin
                if (reset_cmd_i) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase

        poll         = (r_q.st != ST_IDLE) && (r_q.kind == OP_PROG) ? ~r_q.bit7 : 1'b0;
        dq_en_o      = rd_en;
        run_o        = (r_q.st == ST_RUN);
        erase_mask_o = r_q.mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, kind: OP_PROG, bit7: 1'b0, tog: 1'b0, mask: '0};
        end else begin
            r_q <= r_d;
        end
    end

    fst_status_mux u_mux (
        .rd_en_i     (rd_en),
        .show_stat_i (active),
        .poll_i      (poll),
        .tog_i       (r_q.tog),
        .fail_i      (r_q.st == ST_FAIL),
        .arr_i       (arr_data_i),
        .dq_o        (dq_o)
    );

    // R4: toggle flips on an access while status is shown, else holds
    a_r4_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (access && active) |=> (r_q.tog != $past(r_q.tog)));
    a_r4_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !access |=> $stable(r_q.tog));
    // R8: failure is sticky until a reset command
    a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FAIL && !reset_cmd_i) |=> (r_q.st == ST_FAIL));
    a_r8_dq5_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && r_q.st == ST_FAIL) |-> dq_o[5]);
    // R9: no protected sector reaches the erase mask
    a_r9_mask_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && op_start_i && op_kind_i) |=>
            ((erase_mask_o & $past(sect_prot_i)) == '0));
    // R11: starts outside idle leave the latched operation alone
    a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |=> ($stable(r_q.kind) && $stable(r_q.bit7) && $stable(erase_mask_o)));
    // R6 R7: fake-busy windows never start the model
    a_r6_fake_no_run: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FAKE) |-> !run_o);
    // R1 R5: idle reads carry array data
    a_r5_idle_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && r_q.st == ST_IDLE && !erase_hold_i) |-> (dq_o == arr_data_i));
    // R4: low status bits are always clear
    a_r4_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && active) |-> (dq_o[4:0] == 5'b00000));
endmodule

// File: tb/sim_flash_op_status.sv
module sim_flash_op_status;
    localparam int CLK_PERIOD = 10;
    localparam int NSECT      = 8;
    localparam int SW         = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic             op_start_i = 1'b0, op_kind_i = 1'b0;
    logic [SW-1:0]    sect_i = '0;
    logic [NSECT-1:0] erase_sel_i = '0, sect_prot_i = '0;
    logic [7:0]       prog_byte_i = '0, arr_data_i = 8'hA5;
    logic             erase_hold_i = 1'b0, model_done_i = 1'b0;
    logic             model_fail_i = 1'b0, reset_cmd_i = 1'b0;
    logic [7:0]       dq_o;
    logic             dq_en_o, run_o;
    logic [NSECT-1:0] erase_mask_o;

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       smp;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_op_status u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .op_start_i(op_start_i), .op_kind_i(op_kind_i), .sect_i(sect_i),
        .erase_sel_i(erase_sel_i), .sect_prot_i(sect_prot_i),
        .prog_byte_i(prog_byte_i), .erase_hold_i(erase_hold_i),
        .model_done_i(model_done_i), .model_fail_i(model_fail_i),
        .reset_cmd_i(reset_cmd_i), .arr_data_i(arr_data_i),
        .dq_o(dq_o), .dq_en_o(dq_en_o), .run_o(run_o),
        .erase_mask_o(erase_mask_o)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected bytes and compares against the bus
    initial begin
        forever begin
            @(smp);
            if (exp_q.size() == 0) begin
                check(32'(dq_o), 32'hFFFF, "monitor underflow");
            end else begin
                check(32'(dq_o), 32'(exp_q.pop_front()), tag_q.pop_front());
            end
        end
    end

    // driver: one read access, by OE pulse or by CE pulse
    task automatic do_read(input bit via_ce, input logic [7:0] exp, input string tag);
        @(negedge clk);
        if (via_ce) begin
            oe_n = 1'b0;
            @(negedge clk);
            ce_n = 1'b0;
        end else begin
            ce_n = 1'b0;
            oe_n = 1'b0;
        end
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        ->smp;
        #1;
        ce_n = 1'b1;
        oe_n = 1'b1;
        @(posedge clk);
    endtask

    task automatic start_op(input logic kind, input logic [SW-1:0] s,
                            input logic [NSECT-1:0] sel, input logic [NSECT-1:0] prot,
                            input logic [7:0] b);
        @(negedge clk);
        op_kind_i = kind; sect_i = s; erase_sel_i = sel; sect_prot_i = prot;
        prog_byte_i = b; op_start_i = 1'b1;
        @(negedge clk);
        op_start_i = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); model_done_i = 1'b1;
        @(negedge clk); model_done_i = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle_cycles(3);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(32'(dq_en_o), 32'd0, "R1 no drive without read");
        check(32'(dq_o), 32'h00, "R1 bus zero without read");
        check(32'(run_o), 32'd0, "R1 idle run_o");
        do_read(1'b0, 8'hA5, "R1 idle array read");

        // R2 program, bit7 clear
        start_op(1'b0, 3'd2, '0, '0, 8'h3C);
        check(32'(run_o), 32'd1, "R2 run_o during program");
        do_read(1'b0, 8'hC0, "R2 program poll inverted");
        do_read(1'b1, 8'h80, "R4 toggle via CE");
        // R11 erase start while busy is ignored
        start_op(1'b1, 3'd0, 8'hFF, 8'h00, 8'h00);
        check(32'(erase_mask_o), 32'h00, "R11 mask unchanged");
        do_read(1'b0, 8'hC0, "R11 still program status");
        pulse_done();
        arr_data_i = 8'h3C;
        do_read(1'b0, 8'h3C, "R5 data after done");
        do_read(1'b1, 8'h3C, "R5 no toggle after done");

        // R2/R8 program bit7 set, then failure
        start_op(1'b0, 3'd1, '0, '0, 8'hC3);
        do_read(1'b0, 8'h00, "R2 program poll bit7 set");
        @(negedge clk); model_fail_i = 1'b1;
        @(negedge clk); model_fail_i = 1'b0;
        do_read(1'b0, 8'h60, "R8 fail flag set");
        pulse_done();
        do_read(1'b0, 8'h20, "R8 fail sticky over done");
        @(negedge clk); reset_cmd_i = 1'b1;
        @(negedge clk); reset_cmd_i = 1'b0;
        arr_data_i = 8'h77;
        do_read(1'b0, 8'h77, "R8 cleared by reset command");

        // R3/R9 real erase with some protected sectors
        start_op(1'b1, 3'd0, 8'b0000_1111, 8'b0000_0101, 8'h00);
        check(32'(erase_mask_o), 32'h0A, "R9 erase mask skips protected");
        check(32'(run_o), 32'd1, "R3 erase runs");
        do_read(1'b0, 8'h40, "R3 erase poll zero");
        pulse_done();
        do_read(1'b0, 8'h77, "R5 data after erase");

        // R6 protected program
        start_op(1'b0, 3'd3, '0, 8'b0000_1000, 8'h00);
        check(32'(run_o), 32'd0, "R6 no run on protected program");
        do_read(1'b0, 8'h80, "R6 fake busy status");
        do_read(1'b1, 8'hC0, "R6 fake busy toggles");
        idle_cycles(25);
        do_read(1'b0, 8'h77, "R6 back to array after window");

        // R7 all-protected erase
        start_op(1'b1, 3'd0, 8'b0011_0000, 8'b0011_0000, 8'h00);
        check(32'(erase_mask_o), 32'h00, "R7 empty mask");
        check(32'(run_o), 32'd0, "R7 no run");
        do_read(1'b0, 8'h00, "R7 fake erase status");
        idle_cycles(500);
        do_read(1'b0, 8'h40, "R7 still busy mid window");
        idle_cycles(520);
        do_read(1'b0, 8'h77, "R7 back to array after window");

        // R10 erase hold in idle
        @(negedge clk) erase_hold_i = 1'b1;
        do_read(1'b0, 8'h00, "R10 hold status");
        do_read(1'b1, 8'h40, "R10 hold toggles via CE");
        @(negedge clk) erase_hold_i = 1'b0;
        do_read(1'b0, 8'h77, "R10 array after hold");

        idle_cycles(2);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule